// File: doc/BRIEF.md
# Priority-to-Preemption Queue Steering

This block decides, for every frame entering a transmit port, whether it goes to the express queue or to the preemptable queue. Software supplies an 8-bit request mask with one bit per transmit priority. A set bit asks for that priority to be preempted, and a clear bit asks for express handling. The mask is meant to be written only after the link partner has confirmed that it supports preemption. A global enable overrides the mask: while the enable is low, every frame is sent to the express queue.

A change to the request mask does not reach the queue selection at once. The block keeps an effective mapping and a small occupancy counter for each priority. An effective bit takes the value of its request bit only on a cycle when that priority has nothing queued. As a result, the frames of one priority are never spread across both queues at once. The enqueue port is valid/ready. Ready drops while the counter for the offered priority is at its maximum, so the source must hold valid, priority and frame until ready returns. Dequeue notifications come from the scheduler as plain single-cycle pulses, with no back-pressure.

Top module: `prio_steer`

## Requirements
- R1: After reset, the effective mapping is all zeros (every priority express), all occupancy counts are zero, enq_ready is 1, and pending equals the request mask.
- R2: When priority i has zero occupancy and no enqueue of priority i is accepted in a cycle, effective bit i takes the value of request bit i at that clock edge.
- R3: enq_preempt is 1 exactly when steer_en is 1 and the effective bit (not the request bit) of enq_prio is 1. Value 1 means the preemptable queue and value 0 means the express queue.
- R4: While steer_en is 0, enq_preempt is 0 for every priority, whatever the effective mapping holds.
- R5: While priority i has a nonzero occupancy count, effective bit i does not change.
- R6: When an enqueue of priority i is accepted in a cycle where its occupancy is zero, the enqueue uses the old effective bit and the switch of bit i is deferred.
- R7: pending[i] is 1 exactly when request bit i differs from effective bit i.
- R8: enq_ready is 0 while the occupancy of enq_prio is at its maximum (2^OCC_W - 1). An enqueue offered while enq_ready is 0 is not counted.
- R9: A dequeue pulse for a priority whose occupancy is zero is ignored, and the count does not wrap.
- R10: An accepted enqueue and a dequeue of the same priority in the same cycle leave its occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| steer_en | input | 1 | Global enable for preemption steering |
| req_mask | input | NUM_PRIO | Requested mapping, 1 = preemptable |
| enq_valid | input | 1 | Enqueue request valid |
| enq_prio | input | PRIO_W | Priority of the offered frame |
| enq_ready | output | 1 | Enqueue can be accepted |
| enq_preempt | output | 1 | Queue selection for the offered frame, 1 = preemptable |
| deq_valid | input | 1 | Dequeue pulse from the scheduler |
| deq_prio | input | PRIO_W | Priority of the dequeued frame |
| eff_map | output | NUM_PRIO | Mapping currently in effect |
| pending | output | NUM_PRIO | Per-priority flag, request differs from effect |

## Verification
The case that is hardest to reach from the ports is a switch held back by an enqueue that arrives in the very cycle its priority has just drained to zero. The bench reaches it by first draining a priority with a dequeue pulse while its request bit differs from its effective bit, then offering a new frame of that priority on the next cycle, and checking that the effective bit keeps its old value. The full-counter case is reached by filling one priority to its limit. A further offer is then made while ready is low, and the bench counts the dequeues needed before the switch occurs, which shows whether that offer was wrongly counted.

// File: rtl/prio_steer_pkg.sv
package prio_steer_pkg;

  typedef enum logic {
    QSEL_EXPRESS = 1'b0,
    QSEL_PREEMPT = 1'b1
  } qsel_e;

  // Queue choice for one frame given the global enable and its mapping bit
  function automatic qsel_e pick_queue(input logic en, input logic map_bit);
    return (en && map_bit) ? QSEL_PREEMPT : QSEL_EXPRESS;
  endfunction

endpackage

// File: rtl/prio_occ_cnt.sv
module prio_occ_cnt #(
  parameter int OCC_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic is_zero,
  output logic is_full
);

  logic [OCC_W-1:0] cnt_q;
  logic             dec_ok;

  // A dequeue with nothing counted is dropped
  assign dec_ok  = dec && (cnt_q != '0);
  assign is_zero = (cnt_q == '0);
  assign is_full = (cnt_q == '1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      case ({inc, dec_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

endmodule

// File: rtl/prio_map_bit.sv
module prio_map_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic req_bit,
  input  logic occ_zero,
  input  logic enq_hit,
  output logic eff_bit
);

  // The switch is allowed only on an idle priority; an arriving frame wins
  logic may_switch;
  assign may_switch = occ_zero && !enq_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eff_bit <= 1'b0;
    end else if (may_switch) begin
      eff_bit <= req_bit;
    end
  end

endmodule

// File: rtl/prio_steer.sv
module prio_steer
  import prio_steer_pkg::*;
#(
  parameter int NUM_PRIO = 8,
  parameter int OCC_W    = 4,
  localparam int PRIO_W  = (NUM_PRIO > 1) ? $clog2(NUM_PRIO) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                steer_en,
  input  logic [NUM_PRIO-1:0] req_mask,
  input  logic                enq_valid,
  input  logic [PRIO_W-1:0]   enq_prio,
  output logic                enq_ready,
  output logic                enq_preempt,
  input  logic                deq_valid,
  input  logic [PRIO_W-1:0]   deq_prio,
  output logic [NUM_PRIO-1:0] eff_map,
  output logic [NUM_PRIO-1:0] pending
);

  logic [NUM_PRIO-1:0] occ_zero;
  logic [NUM_PRIO-1:0] occ_full;
  logic [NUM_PRIO-1:0] enq_hit;
  logic [NUM_PRIO-1:0] deq_hit;
  logic                enq_fire;
  qsel_e               sel;

  assign enq_ready = !occ_full[enq_prio];
  assign enq_fire  = enq_valid && enq_ready;

  for (genvar i = 0; i < NUM_PRIO; i++) begin : g_prio
    assign enq_hit[i] = enq_fire  && (enq_prio == PRIO_W'(i));
    assign deq_hit[i] = deq_valid && (deq_prio == PRIO_W'(i));

    prio_occ_cnt #(.OCC_W(OCC_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc     (enq_hit[i]),
      .dec     (deq_hit[i]),
      .is_zero (occ_zero[i]),
      .is_full (occ_full[i])
    );

    prio_map_bit u_map (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_bit  (req_mask[i]),
      .occ_zero (occ_zero[i]),
      .enq_hit  (enq_hit[i]),
      .eff_bit  (eff_map[i])
    );
  end

  assign sel         = pick_queue(steer_en, eff_map[enq_prio]);
  assign enq_preempt = (sel == QSEL_PREEMPT);
  assign pending     = req_mask ^ eff_map;

endmodule

// File: rtl/prio_steer_chk.sv
module prio_steer_chk #(
  parameter int NUM_PRIO = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                steer_en,
  input logic                enq_valid,
  input logic                enq_preempt,
  input logic [NUM_PRIO-1:0] req_mask,
  input logic [NUM_PRIO-1:0] eff_map,
  input logic [NUM_PRIO-1:0] occ_zero,
  input logic [NUM_PRIO-1:0] enq_hit,
  input logic [NUM_PRIO-1:0] deq_hit
);

  // R4
  express_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!steer_en && enq_valid) |-> !enq_preempt);

  for (genvar i = 0; i < NUM_PRIO; i++) begin : g_bit
    // R2
    map_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (occ_zero[i] && !enq_hit[i]) |=> (eff_map[i] == $past(req_mask[i])));

    // R5
    map_hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !occ_zero[i] |=> $stable(eff_map[i]));

    // R6
    enq_defers_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (occ_zero[i] && enq_hit[i]) |=> $stable(eff_map[i]));

    // R9
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (occ_zero[i] && deq_hit[i] && !enq_hit[i]) |=> occ_zero[i]);
  end

endmodule

bind prio_steer prio_steer_chk #(.NUM_PRIO(NUM_PRIO)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .steer_en    (steer_en),
  .enq_valid   (enq_valid),
  .enq_preempt (enq_preempt),
  .req_mask    (req_mask),
  .eff_map     (eff_map),
  .occ_zero    (occ_zero),
  .enq_hit     (enq_hit),
  .deq_hit     (deq_hit)
);

// File: tb/prio_steer_bench.sv
module prio_steer_bench;

  localparam int NP   = 8;
  localparam int PW   = 3;
  localparam int OW   = 4;
  localparam int NV   = 16;
  localparam int VW   = 27;
  localparam int MAXC = (1 << OW) - 1;

  // Vector: en | mask[8] | ev | ep[3] | dv | dp[3] | exp_eff[8] | exp_pre | exp_rdy
  localparam logic [VW-1:0] VECS [0:NV-1] = '{
    {1'b1, 8'h00, 1'b0, 3'd0, 1'b0, 3'd0, 8'h00, 1'b0, 1'b1},
    {1'b1, 8'h0F, 1'b1, 3'd0, 1'b0, 3'd0, 8'h00, 1'b0, 1'b1},
    {1'b1, 8'h0F, 1'b1, 3'd1, 1'b0, 3'd0, 8'h0E, 1'b1, 1'b1},
    {1'b1, 8'h0F, 1'b0, 3'd0, 1'b1, 3'd0, 8'h0E, 1'b0, 1'b1},
    {1'b1, 8'h0F, 1'b0, 3'd0, 1'b0, 3'd0, 8'h0E, 1'b0, 1'b1},
    {1'b0, 8'h0F, 1'b1, 3'd0, 1'b0, 3'd0, 8'h0F, 1'b0, 1'b1},
    {1'b1, 8'h00, 1'b1, 3'd0, 1'b0, 3'd0, 8'h0F, 1'b1, 1'b1},
    {1'b1, 8'h00, 1'b0, 3'd1, 1'b1, 3'd1, 8'h03, 1'b1, 1'b1},
    {1'b1, 8'h00, 1'b1, 3'd1, 1'b1, 3'd0, 8'h03, 1'b1, 1'b1},
    {1'b1, 8'h00, 1'b1, 3'd0, 1'b1, 3'd0, 8'h03, 1'b1, 1'b1},
    {1'b1, 8'h00, 1'b0, 3'd0, 1'b1, 3'd0, 8'h03, 1'b1, 1'b1},
    {1'b1, 8'h00, 1'b0, 3'd0, 1'b1, 3'd1, 8'h03, 1'b1, 1'b1},
    {1'b1, 8'h00, 1'b0, 3'd1, 1'b1, 3'd1, 8'h02, 1'b1, 1'b1},
    {1'b1, 8'h00, 1'b0, 3'd1, 1'b0, 3'd0, 8'h00, 1'b0, 1'b1},
    {1'b1, 8'h80, 1'b0, 3'd7, 1'b0, 3'd0, 8'h00, 1'b0, 1'b1},
    {1'b1, 8'h80, 1'b1, 3'd7, 1'b0, 3'd0, 8'h80, 1'b1, 1'b1}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          steer_en = 1'b0;
  logic [NP-1:0] req_mask = '0;
  logic          enq_valid = 1'b0;
  logic [PW-1:0] enq_prio = '0;
  logic          enq_ready;
  logic          enq_preempt;
  logic          deq_valid = 1'b0;
  logic [PW-1:0] deq_prio = '0;
  logic [NP-1:0] eff_map;
  logic [NP-1:0] pending;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  prio_steer #(.NUM_PRIO(NP), .OCC_W(OW)) u_prio_steer (
    .clk         (clk),
    .rst_n       (rst_n),
    .steer_en    (steer_en),
    .req_mask    (req_mask),
    .enq_valid   (enq_valid),
    .enq_prio    (enq_prio),
    .enq_ready   (enq_ready),
    .enq_preempt (enq_preempt),
    .deq_valid   (deq_valid),
    .deq_prio    (deq_prio),
    .eff_map     (eff_map),
    .pending     (pending)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [VW-1:0] v;
    logic [7:0]    exp_eff;

    repeat (3) @(negedge clk);
    req_mask = 8'h3C;
    #1;
    // R1: reset state
    check("R1 eff_map", 32'(eff_map), 32'h00);
    check("R1 pending", 32'(pending), 32'h3C);
    check("R1 enq_ready", 32'(enq_ready), 32'h1);
    req_mask = 8'h00;
    @(negedge clk);
    rst_n = 1'b1;

    // Table walk: R2 R3 R4 R5 R6 R7 R9 R10
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      v = VECS[k];
      steer_en  = v[26];
      req_mask  = v[25:18];
      enq_valid = v[17];
      enq_prio  = v[16:14];
      deq_valid = v[13];
      deq_prio  = v[12:10];
      exp_eff   = v[9:2];
      #1;
      check($sformatf("R2 R5 R6 R9 R10 eff_map vec %0d", k), 32'(eff_map), 32'(exp_eff));
      check($sformatf("R3 R4 enq_preempt vec %0d", k), 32'(enq_preempt), 32'(v[1]));
      check($sformatf("R8 enq_ready vec %0d", k), 32'(enq_ready), 32'(v[0]));
      check($sformatf("R7 pending vec %0d", k), 32'(pending), 32'(v[25:18] ^ exp_eff));
    end

    // Directed R8: fill priority 5, offer one more while full, drain
    @(negedge clk);
    enq_valid = 1'b0;
    deq_valid = 1'b0;
    req_mask  = 8'h80;
    for (int k = 0; k < MAXC; k++) begin
      @(negedge clk);
      enq_valid = 1'b1;
      enq_prio  = 3'd5;
    end
    @(negedge clk);
    #1;
    check("R8 ready low when full", 32'(enq_ready), 32'h0);
    @(negedge clk);
    enq_valid = 1'b0;
    req_mask  = 8'hA0;
    #1;
    check("R7 pending while full", 32'(pending), 32'h20);
    for (int k = 0; k < MAXC; k++) begin
      @(negedge clk);
      deq_valid = 1'b1;
      deq_prio  = 3'd5;
      if (k == MAXC - 1) begin
        #1;
        check("R5 bit held before last dequeue", 32'(eff_map[5]), 32'h0);
      end
    end
    @(negedge clk);
    deq_valid = 1'b0;
    #1;
    check("R8 R5 bit held on drain edge", 32'(eff_map[5]), 32'h0);
    check("R8 ready back after drain", 32'(enq_ready), 32'h1);
    @(negedge clk);
    #1;
    check("R8 R2 switch after exact drain", 32'(eff_map[5]), 32'h1);
    check("R7 pending clear", 32'(pending), 32'h00);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule